// File: doc/BRIEF.md
# Fully Associative Translation Cache with Recency Ranks

This block caches virtual-to-physical page mappings. It searches every stored mapping at once for the page number of an incoming virtual address. On a match it returns the physical address, which is the cached physical page number joined to the untouched page offset, along with the page's permission bits. The search is combinational, and its outputs follow the address input whether or not an access is strobed. Only a strobed access changes state, and it does so at the next rising clock edge.

Each slot keeps a recency rank: 0 marks the most recent use, and larger values mark older uses. Slots that are empty sit at the largest rank. When the caller misses, it fetches the mapping elsewhere and presents it on the fill port. The fill goes into an empty slot if one exists. Otherwise it overwrites the slot that was used longest ago. Loading a new page table base invalidates every cached mapping, and the flush input serves that purpose.

Top module: `tlb_fa`

## Requirements
- R1: With the default geometry (16-bit virtual and physical addresses, 8-bit page offset, 8 slots), a hit drives `paddr_o` = {stored physical page number, `acc_vaddr_i[7:0]`} in the same cycle.
- R2: `hit_o` is 1 exactly when a valid slot holds the page number `acc_vaddr_i[15:8]`. On a hit, `perm_o`, `hit_dirty_o` and `hit_rank_o` show that slot's fields. With `acc_valid_i` low, the search changes no state.
- R3: A strobed access that hits sets the hit slot's rank to 0. Every valid slot whose rank was below the hit slot's old rank gains one. All other ranks are unchanged.
- R4: An invalid slot always holds rank ENTRIES-1 (7), so valid slots are never pushed past the slots in use. After a flush, successive fills produce ranks 0, 1, 2 ... among the filled slots.
- R5: A fill while some slot is invalid writes the lowest-index invalid slot with rank 0, and every valid slot gains one rank. The number of valid slots grows by one.
- R6: A fill while all slots are valid replaces the slot with rank 7. The new mapping takes rank 0, and the replaced page number no longer hits.
- R7: A strobed write, whether a hit or a fill with `fill_write_i`=1, sets the slot's dirty bit. A read hit leaves the dirty bit unchanged, and a read fill clears it.
- R8: `flush_i` clears every valid bit at the next edge. It takes precedence over a fill or access presented in the same cycle.
- R9: After reset no slot is valid, so every search misses.
- R10: A fill and a strobed access are never presented together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all slots (page table base reload) |
| acc_valid_i | input | 1 | Strobe: access updates rank/dirty on hit |
| acc_write_i | input | 1 | Access is a write |
| acc_vaddr_i | input | VA_W | Virtual address searched |
| hit_o | output | 1 | Search matched a valid slot |
| paddr_o | output | PA_W | Translated physical address (0 on miss) |
| perm_o | output | PERM_W | Permission bits of hit slot |
| hit_dirty_o | output | 1 | Dirty bit of hit slot |
| hit_rank_o | output | RANK_W | Recency rank of hit slot |
| fill_valid_i | input | 1 | Install a mapping |
| fill_write_i | input | 1 | Installing access was a write (sets dirty) |
| fill_vpn_i | input | VA_W-OFF_W | Virtual page number to install |
| fill_ppn_i | input | PA_W-OFF_W | Physical page number to install |
| fill_perm_i | input | PERM_W | Permission bits to install |

## Verification
A flush and a fill may reach the block in the same cycle. The bench provokes this by raising `flush_i` together with a fill of a new page while the cache is full. Three results show that the flush won: the freshly presented page misses afterwards, and so do the pages cached before. The next two fills come out at ranks 1 and 0, which could not happen if any stale valid slot survived.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VA_W_DEF    = 16;
  localparam int unsigned TLB_PA_W_DEF    = 16;
  localparam int unsigned TLB_OFF_W_DEF   = 8;
  localparam int unsigned TLB_ENTRIES_DEF = 8;
  localparam int unsigned TLB_PERM_W_DEF  = 2;

  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_HIT,
    UPD_FILL
  } tlb_upd_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [TAG_W-1:0] key_i,
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [N-1:0]     valid_i,
  output logic [N-1:0]     match_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  // R2: page numbers are unique among valid slots
  always_comb begin
    if (!$isunknown(match_o)) begin
      p_unique_match_r2: assert ($onehot0(match_o));
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W   = $clog2(N),
  localparam int unsigned RANK_W  = IDX_W,
  localparam logic [RANK_W-1:0] RANK_MAX = RANK_W'(N - 1)
) (
  input  logic [N-1:0]      valid_i,
  input  logic [RANK_W-1:0] rank_i [N],
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] free_idx, old_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    old_idx  = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (rank_i[i] == RANK_MAX) old_idx = IDX_W'(i);
    end
  end

  assign idx_o = any_free ? free_idx : old_idx;
endmodule

// File: rtl/tlb_rank.sv
module tlb_rank #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W  = $clog2(N),
  localparam int unsigned RANK_W = IDX_W
) (
  input  logic [N-1:0]      valid_i,
  input  logic [RANK_W-1:0] rank_i [N],
  input  logic [IDX_W-1:0]  tgt_i,
  output logic [RANK_W-1:0] rank_o [N]
);
  logic [RANK_W-1:0] old_rank;

  assign old_rank = rank_i[tgt_i];

  for (genvar g = 0; g < N; g++) begin : g_nxt
    always_comb begin
      if (IDX_W'(g) == tgt_i)
        rank_o[g] = '0;
      else if (valid_i[g] && (rank_i[g] < old_rank))
        rank_o[g] = rank_i[g] + RANK_W'(1);
      else
        rank_o[g] = rank_i[g];
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = TLB_VA_W_DEF,
  parameter int unsigned PA_W    = TLB_PA_W_DEF,
  parameter int unsigned OFF_W   = TLB_OFF_W_DEF,
  parameter int unsigned ENTRIES = TLB_ENTRIES_DEF,
  parameter int unsigned PERM_W  = TLB_PERM_W_DEF,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned RANK_W = IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [VA_W-1:0]   acc_vaddr_i,
  output logic              hit_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [PERM_W-1:0] perm_o,
  output logic              hit_dirty_o,
  output logic [RANK_W-1:0] hit_rank_o,
  input  logic              fill_valid_i,
  input  logic              fill_write_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PERM_W-1:0] fill_perm_i
);
  localparam logic [RANK_W-1:0] RANK_MAX = RANK_W'(ENTRIES - 1);

  logic [VPN_W-1:0]  tag_q   [ENTRIES];
  logic [PPN_W-1:0]  ppn_q   [ENTRIES];
  logic [PERM_W-1:0] perm_q  [ENTRIES];
  logic [RANK_W-1:0] rank_q  [ENTRIES];
  logic [RANK_W-1:0] rank_nx [ENTRIES];
  logic [ENTRIES-1:0] valid_q, dirty_q, match;

  logic             cam_hit;
  logic [IDX_W-1:0] hit_idx, vic_idx, tgt_idx;
  tlb_upd_e         upd;

  tlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_cam (
    .key_i   (acc_vaddr_i[VA_W-1:OFF_W]),
    .tag_i   (tag_q),
    .valid_i (valid_q),
    .match_o (match),
    .hit_o   (cam_hit),
    .idx_o   (hit_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .valid_i (valid_q),
    .rank_i  (rank_q),
    .idx_o   (vic_idx)
  );

  always_comb begin
    if (fill_valid_i)                upd = UPD_FILL;
    else if (acc_valid_i && cam_hit) upd = UPD_HIT;
    else                             upd = UPD_NONE;
  end

  assign tgt_idx = (upd == UPD_FILL) ? vic_idx : hit_idx;

  tlb_rank #(.N(ENTRIES)) u_rank (
    .valid_i (valid_q),
    .rank_i  (rank_q),
    .tgt_i   (tgt_idx),
    .rank_o  (rank_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
        rank_q[i] <= RANK_MAX;
      end
    end else if (flush_i) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= RANK_MAX;
    end else if (upd != UPD_NONE) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= rank_nx[i];
      if (upd == UPD_FILL) begin
        valid_q[vic_idx] <= 1'b1;
        dirty_q[vic_idx] <= fill_write_i;
        tag_q[vic_idx]   <= fill_vpn_i;
        ppn_q[vic_idx]   <= fill_ppn_i;
        perm_q[vic_idx]  <= fill_perm_i;
      end else if (acc_write_i) begin
        dirty_q[hit_idx] <= 1'b1;
      end
    end
  end

  assign hit_o       = cam_hit;
  assign paddr_o     = cam_hit ? {ppn_q[hit_idx], acc_vaddr_i[OFF_W-1:0]} : '0;
  assign perm_o      = cam_hit ? perm_q[hit_idx] : '0;
  assign hit_dirty_o = cam_hit && dirty_q[hit_idx];
  assign hit_rank_o  = cam_hit ? rank_q[hit_idx] : '0;

  // R10: fill and strobed access are exclusive
  p_fill_xor_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_i && acc_valid_i));

  // R8: flush leaves nothing valid
  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  // R5: fill into a free slot grows the valid count by one
  p_fill_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && !(&valid_q))
      |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  // R6: fill into a full cache keeps it full
  p_evict_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && (&valid_q)) |=> (&valid_q));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R4: empty slots park at the top rank
    p_park_rank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_q[g] |-> (rank_q[g] == RANK_MAX));
    // R3: strobed hit becomes most recent
    p_hit_mru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && match[g] && !fill_valid_i && !flush_i) |=> (rank_q[g] == '0));
    // R7: write hit marks dirty
    p_write_dirty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_write_i && match[g] && !fill_valid_i && !flush_i) |=> dirty_q[g]);
    // R7: read hit keeps dirty
    p_read_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && !acc_write_i && match[g] && !fill_valid_i && !flush_i)
        |=> (dirty_q[g] == $past(dirty_q[g])));
  end
endmodule

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] vaddr = '0;
  logic       hit, hit_dirty;
  logic [15:0] paddr;
  logic [1:0] perm;
  logic [2:0] rank;
  logic       fill_valid = 1'b0, fill_write = 1'b0;
  logic [7:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0] fill_perm = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlb_fa u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_vaddr_i(vaddr),
    .hit_o(hit), .paddr_o(paddr), .perm_o(perm), .hit_dirty_o(hit_dirty),
    .hit_rank_o(rank), .fill_valid_i(fill_valid), .fill_write_i(fill_write),
    .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm)
  );

  // step: [18] fill, [17] write, [16:9] vpn, [8:1] ppn (fill value or expected), [0] expected hit
  localparam logic [18:0] STEPS [15] = '{
    {1'b1, 1'b0, 8'h20, 8'h12, 1'b0},
    {1'b1, 1'b0, 8'h11, 8'h14, 1'b0},
    {1'b1, 1'b0, 8'hff, 8'h16, 1'b0},
    {1'b1, 1'b1, 8'hac, 8'h15, 1'b0},
    {1'b1, 1'b1, 8'h10, 8'h13, 1'b0},
    {1'b1, 1'b1, 8'h01, 8'h11, 1'b0},
    {1'b0, 1'b0, 8'h11, 8'h14, 1'b1},
    {1'b0, 1'b1, 8'h13, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h13, 8'h17, 1'b0},
    {1'b0, 1'b1, 8'h20, 8'h12, 1'b1},
    {1'b0, 1'b1, 8'h23, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h23, 8'h18, 1'b0},
    {1'b0, 1'b0, 8'h20, 8'h12, 1'b1},
    {1'b0, 1'b1, 8'h34, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h34, 8'h19, 1'b0}
  };

  // final: [20:13] vpn, [12:5] ppn, [4] present, [3] dirty, [2:0] rank
  localparam logic [20:0] FINAL [9] = '{
    {8'h01, 8'h11, 1'b1, 1'b1, 3'd5},
    {8'h13, 8'h17, 1'b1, 1'b1, 3'd3},
    {8'h10, 8'h13, 1'b1, 1'b1, 3'd6},
    {8'h20, 8'h12, 1'b1, 1'b1, 3'd1},
    {8'h23, 8'h18, 1'b1, 1'b1, 3'd2},
    {8'h11, 8'h14, 1'b1, 1'b0, 3'd4},
    {8'hac, 8'h15, 1'b1, 1'b1, 3'd7},
    {8'h34, 8'h19, 1'b1, 1'b1, 3'd0},
    {8'hff, 8'h00, 1'b0, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_fill(input logic wr, input logic [7:0] vpn, input logic [7:0] ppn,
                         input logic [1:0] pm);
    fill_valid = 1'b1; fill_write = wr; fill_vpn = vpn; fill_ppn = ppn; fill_perm = pm;
    @(negedge clk);
    fill_valid = 1'b0; fill_write = 1'b0;
  endtask

  task automatic do_access(input logic wr, input logic [15:0] va, output logic h,
                           output logic [15:0] pa);
    vaddr = va; acc_valid = 1'b1; acc_write = wr;
    #1; h = hit; pa = paddr;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic peek(input logic [15:0] va);
    vaddr = va; #1;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic h;
    logic [15:0] pa;
    repeat (3) @(negedge clk);
    // R9: reset state
    peek(16'h0100); chk("R9 miss after reset", hit, 0);
    peek(16'h0000); chk("R9 page 0 miss after reset", hit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    peek(16'h2000); chk("R9 miss after release", hit, 0);

    // worked sequence (R3, R5, R6, R7)
    foreach (STEPS[i]) begin
      if (STEPS[i][18]) begin
        do_fill(STEPS[i][17], STEPS[i][16:9], STEPS[i][8:1], 2'b11);
      end else begin
        do_access(STEPS[i][17], {STEPS[i][16:9], 8'h5a}, h, pa);
        chk($sformatf("R2 hit step %0d", i), h, STEPS[i][0]);
        if (STEPS[i][0]) chk($sformatf("R1 paddr step %0d", i), pa, {STEPS[i][8:1], 8'h5a});
      end
    end
    foreach (FINAL[i]) begin
      peek({FINAL[i][20:13], 8'h33});
      chk($sformatf("R6 present vpn %0h", FINAL[i][20:13]), hit, FINAL[i][4]);
      if (FINAL[i][4]) begin
        chk($sformatf("R3 rank vpn %0h", FINAL[i][20:13]), rank, FINAL[i][2:0]);
        chk($sformatf("R7 dirty vpn %0h", FINAL[i][20:13]), hit_dirty, FINAL[i][3]);
        chk($sformatf("R1 paddr vpn %0h", FINAL[i][20:13]), paddr, {FINAL[i][12:5], 8'h33});
      end
    end
    // R2: peeking again changed nothing
    peek(16'h0100); chk("R2 peek leaves rank", rank, 5);

    // R8: flush collides with a fill, flush wins
    flush = 1'b1;
    do_fill(1'b0, 8'h55, 8'h66, 2'b01);
    flush = 1'b0;
    peek(16'h5500); chk("R8 colliding fill dropped", hit, 0);
    peek(16'h0100); chk("R8 old page gone", hit, 0);
    peek(16'h3400); chk("R8 newest page gone", hit, 0);

    // R4/R5: ranks restart from a clean order
    do_fill(1'b0, 8'h40, 8'h2a, 2'b01);
    do_fill(1'b0, 8'h41, 8'h2b, 2'b10);
    peek(16'h40c3);
    chk("R4 first fill rank", rank, 1);
    chk("R1 offset passthrough", paddr, 16'h2ac3);
    chk("R2 perm", perm, 2'b01);
    chk("R7 read fill clean", hit_dirty, 0);
    peek(16'h4100); chk("R5 new fill rank", rank, 0);
    chk("R2 perm second", perm, 2'b10);

    // R3/R7: read hit keeps clean, write hit dirties
    do_access(1'b0, 16'h4001, h, pa);
    peek(16'h4000); chk("R3 read hit rank", rank, 0); chk("R7 read keeps clean", hit_dirty, 0);
    peek(16'h4100); chk("R3 demoted", rank, 1);
    do_access(1'b1, 16'h4101, h, pa);
    peek(16'h4100); chk("R7 write dirties", hit_dirty, 1); chk("R3 write hit rank", rank, 0);
    peek(16'h4000); chk("R3 other demoted", rank, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule